// File: doc/BRIEF.md
# Pixel Packing Ping-Pong Line Buffer

This block sits on the capture path of an image pipeline. It takes one 8-bit pixel per valid strobe and gathers four pixels into each 32-bit word, so that every access to the frame memory moves four pixels at once. Pixels are written into four byte-wide lanes. The lane being written moves on after every second pixel. Two complete four-lane sets are kept: while one set fills with the current line, the other set drains toward memory as 32-bit words over a valid/ready handshake.

A horizontal sync pulse ends a line and swaps the roles of the two sets. The set that was just filled becomes the one being drained, and the previous drain set starts to fill. If words from the previous line are still waiting when the sync arrives, they are dropped, the swap happens anyway, and a sticky overflow flag is raised. A vertical sync pulse empties both sets, clears every counter and clears the flag. The line length and the pixel width are parameters. The number of word addresses per lane is a quarter of the line length.

Top module: `pix_pack_lb`

## Requirements
- R1: Word a of a line has lane k in bits [8k+7:8k], k = 0..3. Lane k holds the line's pixel number 8*(a/2) + 2k + (a mod 2), where pixels are counted from 0 at the start of the line. Line pixels 0,2,4,6 form word 0, pixels 1,3,5,7 form word 1, and so on.
- R2: The words of a line are presented in increasing address order, starting at 0.
- R3: On the first cycle after the hsync that ends a line, that line's first word is on word_o with word_vld_o high. Pixels arriving meanwhile go into the other set.
- R4: A line of n accepted pixels yields 2*floor(n/8) words. A trailing group of fewer than eight pixels is not output.
- R5: Pixels beyond LINE_PIX within one line are ignored, so a line yields at most LINE_PIX/4 words.
- R6: word_vld_o is high exactly while undrained words of the current drain set remain. word_o only moves to the next word on a cycle with word_vld_o and word_rdy_i both high.
- R7: An hsync that arrives while words remain undrained sets ovf_o and discards those words, and the sets still swap. A handshake in the same cycle as the hsync counts as completed, so taking the last word in that cycle does not set ovf_o.
- R8: Once set, ovf_o stays high until a vsync.
- R9: A pixel presented in the same cycle as hsync becomes pixel 0 of the next line.
- R10: A vsync empties both sets and clears ovf_o, so word_vld_o and ovf_o are low in the following cycle. It takes priority over an hsync or a pixel in the same cycle, and that pixel is dropped.
- R11: After reset, word_vld_o and ovf_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_i | input | PIX_W | Pixel value |
| pix_vld_i | input | 1 | Pixel strobe |
| hsync_i | input | 1 | One-cycle line sync pulse |
| vsync_i | input | 1 | One-cycle frame sync pulse |
| word_o | output | PIX_W*LANES | Packed word toward frame memory |
| word_vld_o | output | 1 | Packed word is valid |
| word_rdy_i | input | 1 | Downstream accepts the word |
| ovf_o | output | 1 | Sticky drain overflow flag |

## Verification
Two events can land on the same clock edge. A pixel strobe can coincide with hsync, and the final drain handshake can coincide with hsync. The bench drives both on purpose. It checks that the coinciding pixel appears as byte 0 of the next line's first word, and that ovf_o stays low when the last word is taken on the sync edge. A behavioural queue model then compares the valid signal, the data and the flag against the design on every cycle, including under random ready stalls.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
   // Role of a buffer set: which of the two four-lane sets is meant
   typedef enum logic {
      SET_A = 1'b0,
      SET_B = 1'b1
   } set_e;
endpackage

// File: rtl/pix_pack_bank.sv
module pix_pack_bank
   import pix_pack_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int LANES = 4,
   parameter int DEPTH = 8,
   parameter int AW    = 3,
   parameter int LW    = 2
) (
   input  logic                   clk,
   input  logic                   we_i,
   input  logic [LW-1:0]          lane_i,
   input  logic [AW-1:0]          addr_i,
   input  logic [PIX_W-1:0]       data_i,
   input  logic [AW-1:0]          raddr_i,
   output logic [PIX_W*LANES-1:0] word_o
);
   // one byte-wide storage per lane, read side shares one address
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [PIX_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we_i && lane_i == LW'(g)) mem[addr_i] <= data_i;
      end
      assign word_o[g*PIX_W +: PIX_W] = mem[raddr_i];
   end
endmodule

// File: rtl/pix_pack_wr.sv
module pix_pack_wr
   import pix_pack_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int LINE_PIX = 32,
   parameter int AW       = 3,
   parameter int LW       = 2,
   parameter int PCW      = 6,
   parameter int WCW      = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           vsync_i,
   input  logic           hsync_i,
   input  logic           pix_vld_i,
   output logic           we_o,
   output logic [LW-1:0]  lane_o,
   output logic [AW-1:0]  addr_o,
   output set_e           wset_o,
   output set_e           rset_o,
   output logic [WCW-1:0] words_o
);
   localparam logic [PCW-1:0] LAST = PCW'(LINE_PIX);
   localparam int GROUP = 2 * LANES;

   logic [PCW-1:0] pcnt;
   set_e           wsel;

   always_ff @(posedge clk) begin
      if (!rst_n || vsync_i) begin
         pcnt <= '0;
         wsel <= SET_A;
      end else if (hsync_i) begin
         wsel <= (wsel == SET_A) ? SET_B : SET_A;
         pcnt <= pix_vld_i ? PCW'(1) : '0;
      end else if (pix_vld_i && pcnt < LAST) begin
         pcnt <= pcnt + PCW'(1);
      end
   end

   always_comb begin
      int pi;
      int pc;
      pi      = hsync_i ? 0 : int'(pcnt);
      pc      = int'(pcnt);
      we_o    = pix_vld_i && !vsync_i && (hsync_i || pcnt < LAST);
      lane_o  = LW'((pi / 2) % LANES);
      addr_o  = AW'((pi / GROUP) * 2 + (pi % 2));
      words_o = WCW'((pc / GROUP) * 2);
      if (hsync_i) wset_o = (wsel == SET_A) ? SET_B : SET_A;
      else         wset_o = wsel;
      rset_o  = (wsel == SET_A) ? SET_B : SET_A;
   end
endmodule

// File: rtl/pix_pack_rd.sv
module pix_pack_rd #(
   parameter int AW  = 3,
   parameter int WCW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           vsync_i,
   input  logic           hsync_i,
   input  logic [WCW-1:0] words_i,
   input  logic           rdy_i,
   output logic [AW-1:0]  raddr_o,
   output logic           vld_o,
   output logic           ovf_o
);
   logic [WCW-1:0] rcnt;
   logic [WCW-1:0] rtot;
   logic           fire;
   logic           last;

   assign vld_o   = rcnt < rtot;
   assign fire    = vld_o && rdy_i;
   assign last    = fire && (rcnt + WCW'(1) == rtot);
   assign raddr_o = AW'(rcnt);

   always_ff @(posedge clk) begin
      if (!rst_n || vsync_i) begin
         rcnt  <= '0;
         rtot  <= '0;
         ovf_o <= 1'b0;
      end else if (hsync_i) begin
         if (vld_o && !last) ovf_o <= 1'b1;
         rcnt <= '0;
         rtot <= words_i;
      end else if (fire) begin
         rcnt <= rcnt + WCW'(1);
      end
   end
endmodule

// File: rtl/pix_pack_lb.sv
module pix_pack_lb
   import pix_pack_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int LANES    = 4,
   parameter int LINE_PIX = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PIX_W-1:0]       pix_i,
   input  logic                   pix_vld_i,
   input  logic                   hsync_i,
   input  logic                   vsync_i,
   output logic [PIX_W*LANES-1:0] word_o,
   output logic                   word_vld_o,
   input  logic                   word_rdy_i,
   output logic                   ovf_o
);
   localparam int WORD_W = PIX_W * LANES;
   localparam int DEPTH  = LINE_PIX / LANES;
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LW     = $clog2(LANES);
   localparam int PCW    = $clog2(LINE_PIX + 1);
   localparam int WCW    = $clog2(DEPTH + 1);

   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end
   if (LINE_PIX % (2 * LANES) != 0) begin : g_bad_line
      $error("LINE_PIX must be a multiple of twice LANES");
   end

   logic           we;
   logic [LW-1:0]  wlane;
   logic [AW-1:0]  waddr;
   logic [AW-1:0]  raddr;
   logic [WCW-1:0] words;
   set_e           wset;
   set_e           rset;
   logic [WORD_W-1:0] bank_word [2];

   pix_pack_wr #(
      .LANES(LANES), .LINE_PIX(LINE_PIX), .AW(AW), .LW(LW), .PCW(PCW), .WCW(WCW)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .hsync_i(hsync_i),
      .pix_vld_i(pix_vld_i), .we_o(we), .lane_o(wlane), .addr_o(waddr),
      .wset_o(wset), .rset_o(rset), .words_o(words)
   );

   pix_pack_rd #(.AW(AW), .WCW(WCW)) u_rd (
      .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .hsync_i(hsync_i),
      .words_i(words), .rdy_i(word_rdy_i), .raddr_o(raddr),
      .vld_o(word_vld_o), .ovf_o(ovf_o)
   );

   for (genvar s = 0; s < 2; s++) begin : g_set
      logic bank_we;
      assign bank_we = we && (wset == ((s == 0) ? SET_A : SET_B));
      pix_pack_bank #(
         .PIX_W(PIX_W), .LANES(LANES), .DEPTH(DEPTH), .AW(AW), .LW(LW)
      ) u_bank (
         .clk(clk), .we_i(bank_we), .lane_i(wlane), .addr_i(waddr),
         .data_i(pix_i), .raddr_i(raddr), .word_o(bank_word[s])
      );
   end

   assign word_o = (rset == SET_A) ? bank_word[0] : bank_word[1];
endmodule

// File: rtl/pix_pack_lb_chk.sv
module pix_pack_lb_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hsync_i,
   input logic              vsync_i,
   input logic [WORD_W-1:0] word_o,
   input logic              word_vld_o,
   input logic              word_rdy_i,
   input logic              ovf_o
);
   // R6
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld_o && !word_rdy_i && !hsync_i && !vsync_i) |=> (word_vld_o && $stable(word_o)));

   // R10
   vsync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_i |=> (!word_vld_o && !ovf_o));

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !vsync_i) |=> ovf_o);

   // R7
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync_i && !vsync_i && word_vld_o && !word_rdy_i) |=> ovf_o);

   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> ($past(hsync_i) && !$past(vsync_i)));
endmodule

bind pix_pack_lb pix_pack_lb_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
   .word_o(word_o), .word_vld_o(word_vld_o), .word_rdy_i(word_rdy_i), .ovf_o(ovf_o)
);

// File: tb/pix_pack_lb_tb.sv
`timescale 1ns/1ps
module pix_pack_lb_tb;
   localparam int PIX_W = 8;
   localparam int LANES = 4;
   localparam int LINE_PIX = 32;
   localparam int WORD_W = PIX_W * LANES;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n = 1'b0;
   logic [PIX_W-1:0]  pix_i = '0;
   logic              pix_vld_i = 1'b0;
   logic              hsync_i = 1'b0;
   logic              vsync_i = 1'b0;
   logic [WORD_W-1:0] word_o;
   logic              word_vld_o;
   logic              word_rdy_i = 1'b0;
   logic              ovf_o;

   pix_pack_lb #(.PIX_W(PIX_W), .LANES(LANES), .LINE_PIX(LINE_PIX)) u_dut (
      .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .pix_vld_i(pix_vld_i),
      .hsync_i(hsync_i), .vsync_i(vsync_i), .word_o(word_o),
      .word_vld_o(word_vld_o), .word_rdy_i(word_rdy_i), .ovf_o(ovf_o)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rdy_mode = 0;   // 0 ready, 1 random, 2 stalled
   int taken = 0;

   logic [PIX_W-1:0]  cur [$];
   logic [WORD_W-1:0] q [$];
   logic              m_ovf = 1'b0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // word a, lane k <- pixel 8*(a/2) + 2k + a%2
   task automatic load_words();
      int n;
      q.delete();
      n = (cur.size() / 8) * 2;
      for (int a = 0; a < n; a++) begin
         logic [WORD_W-1:0] w;
         for (int k = 0; k < LANES; k++)
            w[k*PIX_W +: PIX_W] = cur[(a / 2) * 8 + 2 * k + (a % 2)];
         q.push_back(w);
      end
   endtask

   // reference model, updated on the edge from the inputs held over the cycle
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); cur.delete(); m_ovf = 1'b0;
      end else begin
         int fire;
         fire = (q.size() > 0 && word_rdy_i) ? 1 : 0;
         if (vsync_i) begin
            q.delete(); cur.delete(); m_ovf = 1'b0;
         end else if (hsync_i) begin
            if (q.size() - fire > 0) m_ovf = 1'b1;
            load_words();
            cur.delete();
            if (pix_vld_i) cur.push_back(pix_i);
         end else begin
            if (fire == 1) void'(q.pop_front());
            if (pix_vld_i && cur.size() < LINE_PIX) cur.push_back(pix_i);
         end
      end
   end

   // per-cycle comparison at mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         check("R3,R4,R5,R6,R9", "word_vld_o", 32'(word_vld_o), 32'(q.size() > 0));
         if (q.size() > 0 && word_vld_o)
            check("R1,R2", "word_o", word_o, q[0]);
         check("R7,R8,R10", "ovf_o", 32'(ovf_o), 32'(m_ovf));
         if (word_vld_o && word_rdy_i) taken++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step(bit pv, logic [PIX_W-1:0] px, bit hs, bit vs);
      pix_vld_i = pv; pix_i = px; hsync_i = hs; vsync_i = vs;
      if (rdy_mode == 0)      word_rdy_i = 1'b1;
      else if (rdy_mode == 2) word_rdy_i = 1'b0;
      else                    word_rdy_i = 1'($urandom % 2);
      @(posedge clk); #1;
   endtask

   task automatic send_line(int n, bit gaps, bit seq);
      for (int i = 0; i < n; i++) begin
         if (gaps && i % 3 == 2) step(1'b0, '0, 1'b0, 1'b0);
         step(1'b1, seq ? PIX_W'(i) : PIX_W'($urandom), 1'b0, 1'b0);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R11 reset state
      check("R11", "word_vld_o after reset", 32'(word_vld_o), 32'h0);
      check("R11", "ovf_o after reset", 32'(ovf_o), 32'h0);

      // R1 R3 known pixel values, word ready right after the sync
      rdy_mode = 0;
      send_line(LINE_PIX, 1'b0, 1'b1);
      step(1'b0, '0, 1'b1, 1'b0);
      check("R3", "valid after sync", 32'(word_vld_o), 32'h1);
      check("R1", "first word lanes", word_o, 32'h06040200);
      step(1'b0, '0, 1'b0, 1'b0);
      check("R1", "second word lanes", word_o, 32'h07050301);

      // fill while draining, gaps and random stalls
      send_line(LINE_PIX, 1'b1, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      rdy_mode = 1;
      send_line(LINE_PIX, 1'b1, 1'b0);
      rdy_mode = 0;
      step(1'b0, '0, 1'b1, 1'b0);
      idle(12);

      // R5 excess pixels dropped
      send_line(LINE_PIX + 8, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      taken = 0;
      idle(14);
      check("R5", "words from long line", 32'(taken), 32'(LINE_PIX / 4));

      // R4 partial group dropped
      send_line(13, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      taken = 0;
      idle(8);
      check("R4", "words from 13-pixel line", 32'(taken), 32'd2);

      // R9 pixel with sync opens the next line
      send_line(LINE_PIX - 1, 1'b0, 1'b0);
      step(1'b1, 8'h5C, 1'b1, 1'b0);
      send_line(LINE_PIX - 1, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      check("R9", "sync pixel is byte 0", 32'(word_o[7:0]), 32'h5C);
      idle(12);

      // R7 last handshake on the sync edge is no overflow
      step(1'b0, '0, 1'b0, 1'b1);
      send_line(8, 1'b0, 1'b0);
      rdy_mode = 2;
      step(1'b0, '0, 1'b1, 1'b0);
      idle(3);
      rdy_mode = 0;
      step(1'b0, '0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      check("R7", "no overflow when last word taken with sync", 32'(ovf_o), 32'h0);

      // R7 R8 real overflow, then sticky
      rdy_mode = 2;
      send_line(16, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      send_line(8, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      check("R7", "overflow on undrained sync", 32'(ovf_o), 32'h1);
      rdy_mode = 0;
      send_line(LINE_PIX, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      idle(12);
      check("R8", "overflow sticky", 32'(ovf_o), 32'h1);

      // R10 vsync wins over sync and pixel
      send_line(LINE_PIX, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      step(1'b1, 8'hAA, 1'b1, 1'b1);
      check("R10", "valid cleared by vsync", 32'(word_vld_o), 32'h0);
      check("R10", "overflow cleared by vsync", 32'(ovf_o), 32'h0);
      send_line(LINE_PIX, 1'b0, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);
      idle(12);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule